// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides whether an incoming multicast destination address is accepted by a 4096-bit hash table. Software fills the table through a small register port. Each of the 128 table words is 32 bits wide and can be written and read back. Clearing the table means writing zero to every word. Adding an address means setting its bit.

For each lookup the block takes a 12-bit window out of the two most significant address bytes. A 2-bit mode picks the position of that window. The upper seven bits of the window select a table word and the lower five select a bit inside that word. The block reports a hit when that bit is set, the hash enable is on, and the address has its group bit set. The lookup takes two pipeline stages. Stage one registers the window index. Stage two reads the table and registers the hit flag.

In the lookup address, byte k sits at `lk_dmac[8k+7:8k]`. Byte 0 is the first byte on the wire, and its bit 0 is the group bit.

Top module: `mcast_hash_filter`

## Requirements
- R1: Register addresses 0 to 127 each map to one 32-bit table word that can be written and read back. `reg_rdata` shows the word addressed in the cycle before, one clock edge after `reg_addr` is presented.
- R2: Index bits 11:5 select the table word and index bits 4:0 select the bit inside it. The boundary index 0xFFF is word 127, bit 31.
- R3: In mode 0 the index is {byte5, byte4[7:4]}.
- R4: In mode 1 the index is {byte5[6:0], byte4[7:3]}.
- R5: In mode 2 the index is {byte5[5:0], byte4[7:2]}.
- R6: In mode 3 the index is {byte5[3:0], byte4}, and byte5[7:4] is ignored.
- R7: Register address 128 is the control word. Bits 1:0 hold the mode and bit 2 holds the hash enable. Only these three bits are stored and read back. While the enable is clear, `res_hit` stays low. Mode and enable are taken in the cycle that `lk_valid` is high.
- R8: When bit 0 of byte0 is clear, `res_valid` still pulses but `res_hit` stays low.
- R9: `res_valid` pulses high exactly two clock edges after each cycle with `lk_valid` high, and at no other time. `res_hit` is only high together with `res_valid`.
- R10: A table write issued in the same cycle as `lk_valid` is seen by that lookup. A write issued in the cycle after `lk_valid` (the table-read cycle) is not seen by that lookup, but is seen by every later lookup.
- R11: After reset the table words are zero, the control word is zero, and `res_valid` is low.
- R12: Writes to register addresses 129 to 255 change no state, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address: 0 to 127 table, 128 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| lk_valid | input | 1 | Lookup request |
| lk_dmac | input | 48 | Destination address, byte k at bits 8k+7:8k |
| res_valid | output | 1 | Lookup result valid, two edges after request |
| res_hit | output | 1 | Hash hit for that lookup |

## Verification
A lookup result appears on the second rising edge after the cycle in which `lk_valid` was driven. A register read returns on the first edge after the address. The bench drives every input on the falling edge. It samples outputs one time unit after the rising edge on which the result is due. The latency test also samples after the first edge to show that nothing appears early.

The write-collision test places a table write on the falling edge of the request cycle, and then on the falling edge of the table-read cycle. This pins down which edge the new word becomes visible on.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

   // Width of the address field the hash window is cut from (top two bytes)
   localparam int SRC_W     = 16;
   localparam int MODE_W    = 2;
   localparam int NUM_MODES = 1 << MODE_W;

   // Control word field positions
   localparam int CTL_MODE_LSB = 0;
   localparam int CTL_EN_BIT   = 2;
   localparam int CTL_W        = 3;

   typedef struct packed {
      logic              en;
      logic [MODE_W-1:0] mode;
   } mcf_ctl_t;

   // Least significant source bit of the hash window for each mode
   function automatic int win_lsb(input int mode, input int vec_w);
      case (mode)
         0:       return SRC_W - vec_w;
         1:       return SRC_W - 1 - vec_w;
         2:       return SRC_W - 2 - vec_w;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/mcf_vec_sel.sv
module mcf_vec_sel #(
   parameter int VEC_W = 12
) (
   input  logic [mcf_pkg::SRC_W-1:0]  src,
   input  logic [mcf_pkg::MODE_W-1:0] mode,
   output logic [VEC_W-1:0]           vec
);
   localparam int NMODE = mcf_pkg::NUM_MODES;

   logic [NMODE-1:0][VEC_W-1:0] win;

   generate
      if (VEC_W < 1 || VEC_W > mcf_pkg::SRC_W - 2) begin : g_bad_vec_w
         $error("mcf_vec_sel: VEC_W out of range");
      end
      for (genvar m = 0; m < NMODE; m++) begin : g_win
         localparam int LSB = mcf_pkg::win_lsb(m, VEC_W);
         assign win[m] = src[LSB +: VEC_W];
      end
   endgenerate

   assign vec = win[mode];

endmodule

// File: rtl/mcf_table.sv
module mcf_table #(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 128
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
   input  logic [REG_W-1:0]            wr_data,
   input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
   output logic [REG_W-1:0]            rd_data,
   input  logic [$clog2(NUM_REGS)-1:0] lk_row,
   input  logic [$clog2(REG_W)-1:0]    lk_bit,
   output logic                        lk_hit
);
   localparam int IDX_W = $clog2(NUM_REGS);

   logic [NUM_REGS-1:0][REG_W-1:0] rows;
   logic [REG_W-1:0]               lk_word;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
         logic             row_we;
         logic [REG_W-1:0] row_q;

         assign row_we = wr_en && (wr_idx == IDX_W'(r));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (row_we) begin
               row_q <= wr_data;
            end
         end

         assign rows[r] = row_q;
      end
   endgenerate

   assign rd_data = rows[rd_idx];
   assign lk_word = rows[lk_row];
   assign lk_hit  = lk_word[lk_bit];

endmodule

// File: rtl/mcf_ctl.sv
module mcf_ctl #(
   parameter int REG_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [mcf_pkg::CTL_W-1:0] wr_data,
   output mcf_pkg::mcf_ctl_t        ctl,
   output logic [REG_W-1:0]         rd_data
);
   import mcf_pkg::*;

   mcf_ctl_t ctl_q;

   generate
      if (REG_W < CTL_W) begin : g_bad_reg_w
         $error("mcf_ctl: REG_W too narrow for control word");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.en   <= wr_data[CTL_EN_BIT];
         ctl_q.mode <= wr_data[CTL_MODE_LSB +: MODE_W];
      end
   end

   assign ctl     = ctl_q;
   assign rd_data = REG_W'({ctl_q.en, ctl_q.mode});

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 128,
   parameter int ADDR_W   = 8,
   parameter int MAC_W    = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              lk_valid,
   input  logic [MAC_W-1:0]  lk_dmac,
   output logic              res_valid,
   output logic              res_hit
);
   import mcf_pkg::*;

   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int BIT_W = $clog2(REG_W);
   localparam int VEC_W = IDX_W + BIT_W;
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_REGS);

   // Elaboration-time parameter checks
   generate
      if ((1 << IDX_W) != NUM_REGS) begin : g_bad_num_regs
         $error("mcast_hash_filter: NUM_REGS must be a power of two");
      end
      if ((1 << BIT_W) != REG_W) begin : g_bad_reg_w
         $error("mcast_hash_filter: REG_W must be a power of two");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr_w
         $error("mcast_hash_filter: ADDR_W leaves no room for control word");
      end
      if (MAC_W < SRC_W + 1) begin : g_bad_mac_w
         $error("mcast_hash_filter: MAC_W too narrow");
      end
      if (VEC_W > SRC_W - 2) begin : g_bad_vec_w
         $error("mcast_hash_filter: table too large for hash window");
      end
   endgenerate

   // ---------------- register port decode ----------------
   logic             tbl_sel;
   logic             ctl_sel;
   logic             tbl_we;
   logic             ctl_we;
   logic [REG_W-1:0] tbl_rd;
   logic [REG_W-1:0] ctl_rd;

   assign tbl_sel = (reg_addr < CTL_ADDR);
   assign ctl_sel = (reg_addr == CTL_ADDR);
   assign tbl_we  = reg_wen && tbl_sel;
   assign ctl_we  = reg_wen && ctl_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (tbl_sel) begin
         reg_rdata <= tbl_rd;
      end else if (ctl_sel) begin
         reg_rdata <= ctl_rd;
      end else begin
         reg_rdata <= '0;
      end
   end

   // ---------------- control word ----------------
   mcf_ctl_t          ctl_q;
   logic              ctl_en_q;
   logic [MODE_W-1:0] ctl_mode_q;

   mcf_ctl #(.REG_W(REG_W)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_we),
      .wr_data (reg_wdata[CTL_W-1:0]),
      .ctl     (ctl_q),
      .rd_data (ctl_rd)
   );

   assign ctl_en_q   = ctl_q.en;
   assign ctl_mode_q = ctl_q.mode;

   // ---------------- stage 1: hash index ----------------
   logic [SRC_W-1:0] hash_src;
   logic [VEC_W-1:0] hash_vec;
   logic             s1_valid;
   logic             s1_group;
   logic             s1_en;
   logic [VEC_W-1:0] s1_vec;
   logic             dmac_unused;

   assign hash_src    = lk_dmac[MAC_W-1 -: SRC_W];
   assign dmac_unused = ^lk_dmac[MAC_W-SRC_W-1:1];

   mcf_vec_sel #(.VEC_W(VEC_W)) vec_i (
      .src  (hash_src),
      .mode (ctl_mode_q),
      .vec  (hash_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_group <= 1'b0;
         s1_en    <= 1'b0;
         s1_vec   <= '0;
      end else begin
         s1_valid <= lk_valid;
         if (lk_valid) begin
            s1_group <= lk_dmac[0];
            s1_en    <= ctl_en_q;
            s1_vec   <= hash_vec;
         end
      end
   end

   // ---------------- stage 2: table read and hit ----------------
   logic tbl_bit;

   mcf_table #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) tbl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_idx  (reg_addr[IDX_W-1:0]),
      .wr_data (reg_wdata),
      .rd_idx  (reg_addr[IDX_W-1:0]),
      .rd_data (tbl_rd),
      .lk_row  (s1_vec[VEC_W-1:BIT_W]),
      .lk_bit  (s1_vec[BIT_W-1:0]),
      .lk_hit  (tbl_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
      end else begin
         res_valid <= s1_valid;
         res_hit   <= s1_valid && s1_group && s1_en && tbl_bit;
      end
   end

endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 128,
   parameter int ADDR_W   = 8,
   parameter int MAC_W    = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              lk_valid,
   input logic [MAC_W-1:0]  lk_dmac,
   input logic              res_valid,
   input logic              res_hit,
   input logic              ctl_en,
   input logic [1:0]        ctl_mode
);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(NUM_REGS);

   AST_HIT_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> ($past(lk_valid, 2) && $past(lk_dmac[0], 2))); // R8

   AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> $past(ctl_en, 2)); // R7

   AST_HIT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid); // R9

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> ##1 res_valid); // R9

   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_valid, 2)); // R9

   AST_CTL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == CTL_A) |=>
         (ctl_mode == $past(reg_wdata[1:0]) && ctl_en == $past(reg_wdata[2]))); // R7

   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr > CTL_A) |=> (reg_rdata == '0)); // R12

endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(
   .REG_W    (REG_W),
   .NUM_REGS (NUM_REGS),
   .ADDR_W   (ADDR_W),
   .MAC_W    (MAC_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wen   (reg_wen),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .lk_valid  (lk_valid),
   .lk_dmac   (lk_dmac),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .ctl_en    (ctl_en_q),
   .ctl_mode  (ctl_mode_q)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 100000;
   localparam logic [7:0] CTL_A = 8'd128;

   // Entry: {mode[1:0], dmac[47:0], expected index[11:0]}
   localparam int NVEC = 12;
   localparam logic [61:0] VECS [NVEC] = '{
      {2'd0, 48'hFFFF_0000_0001, 12'hFFF},
      {2'd0, 48'h0000_0000_0001, 12'h000},
      {2'd0, 48'h8A3F_0000_0101, 12'h8A3},
      {2'd1, 48'hFFFF_0000_0001, 12'hFFF},
      {2'd1, 48'h1234_5678_9A01, 12'h246},
      {2'd1, 48'h8000_0000_0033, 12'h000},
      {2'd2, 48'hFFFF_0000_0001, 12'hFFF},
      {2'd2, 48'h5AC3_0000_0001, 12'h6B0},
      {2'd2, 48'hC00C_0000_0011, 12'h003},
      {2'd3, 48'hFFFF_0000_0001, 12'hFFF},
      {2'd3, 48'h0F00_0000_0001, 12'hF00},
      {2'd3, 48'hF0FF_0000_0021, 12'h0FF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_dmac = '0;
   logic        res_valid;
   logic        res_hit;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcast_hash_filter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wen   (reg_wen),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .lk_valid  (lk_valid),
      .lk_dmac   (lk_dmac),
      .res_valid (res_valid),
      .res_hit   (res_hit)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b0; reg_addr = a;
      @(posedge clk);
      #1 d = reg_rdata;
   endtask

   task automatic lookup(input logic [47:0] a, output logic v, output logic h);
      @(negedge clk);
      lk_valid = 1'b1; lk_dmac = a;
      @(negedge clk);
      lk_valid = 1'b0;
      @(posedge clk);
      #1 v = res_valid; h = res_hit;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        v, h;
      logic [47:0] probe;

      repeat (3) @(posedge clk);
      #1;
      check("R11 res_valid in reset", {31'b0, res_valid}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: reset contents
      reg_read(CTL_A, rd);      check("R11 control word", rd, 32'h0);
      reg_read(8'd0, rd);       check("R11 table word 0", rd, 32'h0);
      reg_read(8'd127, rd);     check("R11 table word 127", rd, 32'h0);

      // R1: table readback
      reg_write(8'd77, 32'hDEAD_BEEF);
      reg_write(8'd0, 32'h1234_5678);
      reg_read(8'd77, rd);      check("R1 word 77 readback", rd, 32'hDEAD_BEEF);
      reg_read(8'd0, rd);       check("R1 word 0 readback", rd, 32'h1234_5678);
      reg_write(8'd77, 32'h0);
      reg_write(8'd0, 32'h0);

      // R7: only three control bits are kept
      reg_write(CTL_A, 32'hFFFF_FFFF);
      reg_read(CTL_A, rd);      check("R7 control readback", rd, 32'h7);

      // R12: unmapped writes have no effect, reads give zero
      reg_write(8'd200, 32'hFFFF_FFFF);
      reg_write(8'd129, 32'hFFFF_FFFF);
      reg_read(8'd200, rd);     check("R12 unmapped read", rd, 32'h0);
      reg_read(8'd72, rd);      check("R12 no alias word 72", rd, 32'h0);
      reg_read(8'd1, rd);       check("R12 no alias word 1", rd, 32'h0);
      reg_read(CTL_A, rd);      check("R12 control untouched", rd, 32'h7);

      // Table walk: R2 word/bit split, R3..R6 per mode
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  m;
         logic [47:0] a;
         logic [11:0] x;
         string       tag;
         m = VECS[i][61:60];
         a = VECS[i][59:12];
         x = VECS[i][11:0];
         case (m)
            2'd0:    tag = "R3/R2 mode 0";
            2'd1:    tag = "R4/R2 mode 1";
            2'd2:    tag = "R5/R2 mode 2";
            default: tag = "R6/R2 mode 3";
         endcase
         reg_write(CTL_A, {29'b0, 1'b1, m});
         reg_write({1'b0, x[11:5]}, 32'h1 << x[4:0]);
         lookup(a, v, h);
         check({tag, " hit"}, {30'b0, v, h}, 32'h3);
         reg_write({1'b0, x[11:5]}, ~(32'h1 << x[4:0]));
         lookup(a, v, h);
         check({tag, " miss"}, {30'b0, v, h}, 32'h2);
         reg_write({1'b0, x[11:5]}, 32'h0);
      end

      // R7: enable gates the hit; mode 0, probe index 0x8A3 -> word 69 bit 3
      probe = 48'h8A3F_0000_0101;
      reg_write(8'd69, 32'h0000_0008);
      reg_write(CTL_A, 32'h0);
      lookup(probe, v, h);
      check("R7 enable clear no hit", {30'b0, v, h}, 32'h2);
      reg_write(CTL_A, 32'h4);
      lookup(probe, v, h);
      check("R7 enable set hit", {30'b0, v, h}, 32'h3);

      // R8: group bit clear
      lookup(48'h8A3F_0000_0100, v, h);
      check("R8 non-group no hit", {30'b0, v, h}, 32'h2);

      // R9: latency
      @(negedge clk);
      lk_valid = 1'b1; lk_dmac = probe;
      @(posedge clk);
      #1 check("R9 nothing after one edge", {31'b0, res_valid}, 32'h0);
      @(negedge clk);
      lk_valid = 1'b0;
      @(posedge clk);
      #1 check("R9 result after two edges", {30'b0, res_valid, res_hit}, 32'h3);
      @(posedge clk);
      #1 check("R9 single pulse", {31'b0, res_valid}, 32'h0);

      // R10: write in the table-read cycle is not seen by that lookup
      @(negedge clk);
      lk_valid = 1'b1; lk_dmac = probe;
      @(negedge clk);
      lk_valid = 1'b0;
      reg_wen = 1'b1; reg_addr = 8'd69; reg_wdata = 32'h0;
      @(posedge clk);
      #1 check("R10 late write unseen", {30'b0, res_valid, res_hit}, 32'h3);
      @(negedge clk);
      reg_wen = 1'b0;
      lookup(probe, v, h);
      check("R10 later lookup sees write", {30'b0, v, h}, 32'h2);

      // R10: write in the request cycle is seen
      @(negedge clk);
      lk_valid = 1'b1; lk_dmac = probe;
      reg_wen = 1'b1; reg_addr = 8'd69; reg_wdata = 32'h0000_0008;
      @(negedge clk);
      lk_valid = 1'b0; reg_wen = 1'b0;
      @(posedge clk);
      #1 check("R10 same-cycle write seen", {30'b0, res_valid, res_hit}, 32'h3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule